// File: doc/BRIEF.md
# Instruction Control Sequencer

This block is the control unit of a small 8-bit processor with a 16-bit address space. It reads the current instruction register byte and the zero, carry and sign flags, steps a timing state counter that starts at 1, and for each state drives a set of control strobes. The strobes select sources onto the address and data buses, load registers, request a memory read, run the PC increment path and drive the ALU function code. The registers, memory and ALU sit outside the block and see only these strobes.

Each instruction begins with the same five states: an opcode fetch followed by a PC advance. The opcode class then sets what happens next and how long it takes: 8 states for short classes, 10 for a 16-bit register move, 24 for a jump that carries a two-byte target. After the last state of an instruction the counter goes back to 1. A halt opcode freezes the counter until reset.

Top module: `instrSequencer`

## Requirements
- R1: While `rstN` is low and in the first cycle after it, `stateNum` is 1, `halted` is 0 and the strobes show the state-1 pattern.
- R2: Fetch is class-independent: state 1 drives `selPc` and `memRead`; state 2 adds `loadInst`; state 3 drives `selPc` with `loadInc`.
- R3: The PC advance is `loadInc` in state 3, `selInc` alone in state 4, then `selInc` with `loadPc` in state 5.
- R4: Opcode `1000rfff` (ALU class) drives `aluDrive` in states 6 and 7, with `aluFunc` equal to bits 2..0 of the opcode while driven and 0 otherwise; `loadDst` and `loadCc` pulse in state 7; the instruction lasts 8 states.
- R5: Opcode `00xxxxxx` (8-bit move) drives `selSrc` in states 6 and 7, opcode `01xxxxxx` (small immediate) drives `selImm` in states 6 and 7; both pulse `loadDst` in state 7 and last 8 states.
- R6: Opcode `1010dss0` other than the halt code (16-bit move) drives `selSrc` in states 6 to 8 with `loadDst` in state 8 and lasts 10 states.
- R7: Jump opcodes fetch the target as two bytes, high byte first: states 6 to 10 and 11 to 15 each repeat the pattern read, read plus load, `selPc` with `loadInc`, `selInc`, `selInc` with `loadPc`, loading `loadAddrHi` in state 7 and `loadAddrLo` in state 12; a jump lasts 24 states.
- R8: Opcode 11100110 always transfers, 11110000 transfers when S=1, 11101000 when Cy=1, 11100100 when Z=1, 11100010 when Z=0; a transfer drives `selAddr` in states 18 and 19 with `loadPc` in state 19, and an untaken branch drives nothing in states 16 to 24.
- R9: Opcode 11100111 transfers unconditionally and first saves the return address: `selPc` in states 16 and 17 with `loadLink` in state 17.
- R10: Opcode 10101110 is halt: the counter stops at state 6, `halted` rises one cycle later and stays high with every strobe low until reset.
- R11: Any opcode outside the classes above runs fetch and PC advance and then no strobe for states 6 to 8, 8 states in total.
- R12: After the last state of an instruction `stateNum` returns to 1 on the next clock.
- R13: In every state at most one of `selPc`, `selInc`, `selAddr` and at most one of `memRead`, `selSrc`, `selImm`, `aluDrive` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrReg | input | 8 | Current instruction register contents |
| zFlag | input | 1 | Zero flag |
| cyFlag | input | 1 | Carry flag |
| sFlag | input | 1 | Sign flag |
| stateNum | output | 5 | Current timing state, 1-based |
| halted | output | 1 | Sequencer stopped by halt |
| selPc | output | 1 | PC onto address bus |
| memRead | output | 1 | Memory read onto data bus |
| loadInst | output | 1 | Load instruction register |
| loadInc | output | 1 | Load incrementer register |
| selInc | output | 1 | Incrementer onto address bus |
| loadPc | output | 1 | Load PC from address bus |
| selSrc | output | 1 | Source register onto its bus |
| selImm | output | 1 | Immediate field onto data bus |
| loadDst | output | 1 | Load destination register |
| aluDrive | output | 1 | ALU result onto data bus |
| aluFunc | output | 3 | ALU function code |
| loadCc | output | 1 | Load condition-code register |
| loadAddrHi | output | 1 | Load high target byte |
| loadAddrLo | output | 1 | Load low target byte |
| selAddr | output | 1 | Target address onto address bus |
| loadLink | output | 1 | Load return-address register |

## Verification
Random opcode bytes with random flags cover every class and show that the classifier separates the move, immediate, ALU, 16-bit move, jump and undefined groups by their strobe tables and lengths. Each conditional branch is then run with its flag set and clear, which tells a taken transfer from a skipped one, and goto and call run with all flags low to show they ignore the flags. The halt code, which shares the shape of a 16-bit move, is run last to tell the freeze from a 10-state move, followed by reset and a further instruction.

// File: rtl/seqCtlPkg.sv
package seqCtlPkg;

  typedef enum logic [2:0] {
    OP_NOP, OP_MOV8, OP_LDI, OP_ALU, OP_MOV16, OP_JUMP, OP_HALT
  } opClassT;

  typedef struct packed {
    logic selPc;
    logic memRead;
    logic loadInst;
    logic loadInc;
    logic selInc;
    logic loadPc;
    logic selSrc;
    logic selImm;
    logic loadDst;
    logic aluDrive;
    logic loadCc;
    logic loadAddrHi;
    logic loadAddrLo;
    logic selAddr;
    logic loadLink;
  } strobeT;

  // fixed positions in the state sequence
  localparam int EXEC_AT   = 6;   // first state after fetch and PC advance
  localparam int BYTE_STEP = 5;   // states per operand byte
  localparam int LINK_AT   = 16;  // return address save
  localparam int XFER_AT   = 18;  // PC transfer

  localparam logic [7:0] HALT_OP = 8'b1010_1110;
  localparam logic [7:0] CALL_OP = 8'b1110_0111;

  function automatic opClassT classify(input logic [7:0] op);
    opClassT c;
    c = OP_NOP;
    if (op[7:6] == 2'b00)               c = OP_MOV8;
    else if (op[7:6] == 2'b01)          c = OP_LDI;
    else if (op[7:4] == 4'b1000)        c = OP_ALU;
    else if (op == HALT_OP)             c = OP_HALT;
    else if (op[7:4] == 4'b1010 && !op[0]) c = OP_MOV16;
    else if (op == 8'hE6 || op == 8'hE7 || op == 8'hF0 ||
             op == 8'hE8 || op == 8'hE4 || op == 8'hE2) c = OP_JUMP;
    return c;
  endfunction

  function automatic logic jumpTaken(input logic [7:0] op, input logic z,
                                     input logic cy, input logic s);
    logic t;
    case (op)
      8'hF0:   t = s;
      8'hE8:   t = cy;
      8'hE4:   t = z;
      8'hE2:   t = !z;
      default: t = 1'b1;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/seqTimer.sv
module seqTimer #(
  parameter int STATE_W  = 5,
  parameter int LONG_LEN = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] lastState,
  input  logic               haltReq,
  output logic [STATE_W-1:0] state,
  output logic               halted
);
  localparam logic [STATE_W-1:0] FIRST = STATE_W'(1);
  localparam logic [STATE_W-1:0] TOP   = STATE_W'(LONG_LEN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= FIRST;
      halted <= 1'b0;
    end else if (!halted) begin
      if (haltReq)                halted <= 1'b1;
      else if (state == lastState) state <= FIRST;
      else                        state <= state + FIRST;
    end
  end

  p_state_range_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state >= FIRST && state <= TOP));
  p_wrap_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !haltReq && state == lastState) |=> (state == FIRST));
  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(state)));
endmodule

// File: rtl/seqDecode.sv
module seqDecode
  import seqCtlPkg::*;
#(
  parameter int STATE_W   = 5,
  parameter int SHORT_LEN = 8,
  parameter int MID_LEN   = 10,
  parameter int LONG_LEN  = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STATE_W-1:0] state,
  input  logic               halted,
  input  logic [7:0]         instrReg,
  input  logic               zFlag,
  input  logic               cyFlag,
  input  logic               sFlag,
  output strobeT             strb,
  output logic [2:0]         aluFunc,
  output logic [STATE_W-1:0] lastState,
  output logic               haltReq
);
  localparam logic [STATE_W-1:0] S_EXEC = STATE_W'(EXEC_AT);
  localparam logic [STATE_W-1:0] S_STEP = STATE_W'(BYTE_STEP);
  localparam logic [STATE_W-1:0] S_LO   = STATE_W'(EXEC_AT + BYTE_STEP);
  localparam logic [STATE_W-1:0] S_OPND = STATE_W'(EXEC_AT + 2 * BYTE_STEP);
  localparam logic [STATE_W-1:0] S_LINK = STATE_W'(LINK_AT);
  localparam logic [STATE_W-1:0] S_XFER = STATE_W'(XFER_AT);

  opClassT cls;
  logic taken;
  logic [STATE_W-1:0] off;

  assign cls     = classify(instrReg);
  assign taken   = jumpTaken(instrReg, zFlag, cyFlag, sFlag);
  assign haltReq = !halted && cls == OP_HALT && state == S_EXEC;

  always_comb begin
    case (cls)
      OP_MOV16: lastState = STATE_W'(MID_LEN);
      OP_JUMP:  lastState = STATE_W'(LONG_LEN);
      default:  lastState = STATE_W'(SHORT_LEN);
    endcase
  end

  always_comb begin
    off = state - S_EXEC;
    if (off >= S_STEP) off = off - S_STEP;
  end

  always_comb begin
    strb = '0;
    if (!halted) begin
      case (state)
        STATE_W'(1): begin strb.selPc = 1'b1; strb.memRead = 1'b1; end
        STATE_W'(2): begin strb.selPc = 1'b1; strb.memRead = 1'b1; strb.loadInst = 1'b1; end
        STATE_W'(3): begin strb.selPc = 1'b1; strb.loadInc = 1'b1; end
        STATE_W'(4): strb.selInc = 1'b1;
        STATE_W'(5): begin strb.selInc = 1'b1; strb.loadPc = 1'b1; end
        default: ;
      endcase
      if (state >= S_EXEC) begin
        case (cls)
          OP_ALU: begin
            strb.aluDrive = (state <= S_EXEC + 1);
            strb.loadDst  = (state == S_EXEC + 1);
            strb.loadCc   = (state == S_EXEC + 1);
          end
          OP_MOV8: begin
            strb.selSrc  = (state <= S_EXEC + 1);
            strb.loadDst = (state == S_EXEC + 1);
          end
          OP_LDI: begin
            strb.selImm  = (state <= S_EXEC + 1);
            strb.loadDst = (state == S_EXEC + 1);
          end
          OP_MOV16: begin
            strb.selSrc  = (state <= S_EXEC + 2);
            strb.loadDst = (state == S_EXEC + 2);
          end
          OP_JUMP: begin
            if (state < S_OPND) begin
              case (off)
                STATE_W'(0): begin strb.selPc = 1'b1; strb.memRead = 1'b1; end
                STATE_W'(1): begin
                  strb.selPc = 1'b1; strb.memRead = 1'b1;
                  strb.loadAddrHi = (state < S_LO);
                  strb.loadAddrLo = (state >= S_LO);
                end
                STATE_W'(2): begin strb.selPc = 1'b1; strb.loadInc = 1'b1; end
                STATE_W'(3): strb.selInc = 1'b1;
                default:     begin strb.selInc = 1'b1; strb.loadPc = 1'b1; end
              endcase
            end else if (instrReg == CALL_OP && state < S_XFER) begin
              strb.selPc    = 1'b1;
              strb.loadLink = (state == S_LINK + 1);
            end else if (taken && (state == S_XFER || state == S_XFER + 1)) begin
              strb.selAddr = 1'b1;
              strb.loadPc  = (state == S_XFER + 1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign aluFunc = strb.aluDrive ? instrReg[2:0] : 3'b000;

  p_inst_after_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadInst |-> $past(strb.memRead));
  p_pc_after_inc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadPc && strb.selInc) |-> $past(strb.selInc || strb.loadInc));
  p_cc_follows_alu_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCc |-> $past(strb.aluDrive));
  p_addr_bus_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selPc, strb.selInc, strb.selAddr}));
  p_data_bus_r13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.memRead, strb.selSrc, strb.selImm, strb.aluDrive}));
endmodule

// File: rtl/instrSequencer.sv
module instrSequencer
  import seqCtlPkg::*;
#(
  parameter int SHORT_LEN = 8,
  parameter int MID_LEN   = 10,
  parameter int LONG_LEN  = 24,
  localparam int STATE_W  = $clog2(LONG_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [7:0]         instrReg,
  input  logic               zFlag,
  input  logic               cyFlag,
  input  logic               sFlag,
  output logic [STATE_W-1:0] stateNum,
  output logic               halted,
  output logic               selPc,
  output logic               memRead,
  output logic               loadInst,
  output logic               loadInc,
  output logic               selInc,
  output logic               loadPc,
  output logic               selSrc,
  output logic               selImm,
  output logic               loadDst,
  output logic               aluDrive,
  output logic [2:0]         aluFunc,
  output logic               loadCc,
  output logic               loadAddrHi,
  output logic               loadAddrLo,
  output logic               selAddr,
  output logic               loadLink
);
  strobeT strb;
  logic [STATE_W-1:0] lastState;
  logic haltReq;

  seqTimer #(.STATE_W(STATE_W), .LONG_LEN(LONG_LEN)) uTimer (
    .clk(clk), .rstN(rstN), .lastState(lastState), .haltReq(haltReq),
    .state(stateNum), .halted(halted)
  );

  seqDecode #(.STATE_W(STATE_W), .SHORT_LEN(SHORT_LEN), .MID_LEN(MID_LEN),
              .LONG_LEN(LONG_LEN)) uDecode (
    .clk(clk), .rstN(rstN), .state(stateNum), .halted(halted),
    .instrReg(instrReg), .zFlag(zFlag), .cyFlag(cyFlag), .sFlag(sFlag),
    .strb(strb), .aluFunc(aluFunc), .lastState(lastState), .haltReq(haltReq)
  );

  assign {selPc, memRead, loadInst, loadInc, selInc, loadPc, selSrc, selImm,
          loadDst, aluDrive, loadCc, loadAddrHi, loadAddrLo, selAddr, loadLink} = strb;
endmodule

// File: tb/tb_instrSequencer.sv
`timescale 1ns/1ps
module tb_instrSequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] instrReg = 8'h00;
  logic zFlag = 0, cyFlag = 0, sFlag = 0;
  logic [4:0] stateNum;
  logic halted, selPc, memRead, loadInst, loadInc, selInc, loadPc, selSrc, selImm;
  logic loadDst, aluDrive, loadCc, loadAddrHi, loadAddrLo, selAddr, loadLink;
  logic [2:0] aluFunc;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  instrSequencer dut (.*);

  // strobe vector bit order: selPc memRead loadInst loadInc selInc loadPc selSrc
  // selImm loadDst aluDrive loadCc loadAddrHi loadAddrLo selAddr loadLink
  function automatic logic [14:0] actVec();
    return {selPc, memRead, loadInst, loadInc, selInc, loadPc, selSrc, selImm,
            loadDst, aluDrive, loadCc, loadAddrHi, loadAddrLo, selAddr, loadLink};
  endfunction

  function automatic logic [14:0] mk(input bit pc, rd, li, linc, sinc, lpc,
      ssrc, simm, ldst, alu, lcc, lhi, llo, sadr, llk);
    return {pc, rd, li, linc, sinc, lpc, ssrc, simm, ldst, alu, lcc, lhi, llo, sadr, llk};
  endfunction

  // class codes: 0 nop 1 mov8 2 ldi 3 alu 4 mov16 5 jump 6 halt
  function automatic int opKind(input logic [7:0] op);
    if (op[7] == 1'b0) return op[6] ? 2 : 1;
    if (op[7:4] == 4'h8) return 3;
    if (op == 8'hAE) return 6;
    if (op[7:4] == 4'hA && op[0] == 1'b0) return 4;
    if (op inside {8'hE6, 8'hE7, 8'hF0, 8'hE8, 8'hE4, 8'hE2}) return 5;
    return 0;
  endfunction

  function automatic int expLen(input logic [7:0] op);
    case (opKind(op)) 4: return 10; 5: return 24; default: return 8; endcase
  endfunction

  function automatic bit expTaken(input logic [7:0] op, input bit z, c, s);
    case (op) 8'hF0: return s; 8'hE8: return c; 8'hE4: return z;
      8'hE2: return !z; default: return 1; endcase
  endfunction

  function automatic logic [14:0] expVec(input int st, input logic [7:0] op, input bit z, c, s);
    int k = opKind(op);
    case (st)
      1: return mk(1,1,0,0,0,0,0,0,0,0,0,0,0,0,0);
      2: return mk(1,1,1,0,0,0,0,0,0,0,0,0,0,0,0);
      3: return mk(1,0,0,1,0,0,0,0,0,0,0,0,0,0,0);
      4: return mk(0,0,0,0,1,0,0,0,0,0,0,0,0,0,0);
      5: return mk(0,0,0,0,1,1,0,0,0,0,0,0,0,0,0);
      default: ;
    endcase
    if (k == 3 && st == 6) return mk(0,0,0,0,0,0,0,0,0,1,0,0,0,0,0);
    if (k == 3 && st == 7) return mk(0,0,0,0,0,0,0,0,1,1,1,0,0,0,0);
    if (k == 1 && st == 6) return mk(0,0,0,0,0,0,1,0,0,0,0,0,0,0,0);
    if (k == 1 && st == 7) return mk(0,0,0,0,0,0,1,0,1,0,0,0,0,0,0);
    if (k == 2 && st == 6) return mk(0,0,0,0,0,0,0,1,0,0,0,0,0,0,0);
    if (k == 2 && st == 7) return mk(0,0,0,0,0,0,0,1,1,0,0,0,0,0,0);
    if (k == 4 && (st == 6 || st == 7)) return mk(0,0,0,0,0,0,1,0,0,0,0,0,0,0,0);
    if (k == 4 && st == 8) return mk(0,0,0,0,0,0,1,0,1,0,0,0,0,0,0);
    if (k == 5) begin
      case (st)
        6, 11:  return mk(1,1,0,0,0,0,0,0,0,0,0,0,0,0,0);
        7:      return mk(1,1,0,0,0,0,0,0,0,0,0,1,0,0,0);
        12:     return mk(1,1,0,0,0,0,0,0,0,0,0,0,1,0,0);
        8, 13:  return mk(1,0,0,1,0,0,0,0,0,0,0,0,0,0,0);
        9, 14:  return mk(0,0,0,0,1,0,0,0,0,0,0,0,0,0,0);
        10, 15: return mk(0,0,0,0,1,1,0,0,0,0,0,0,0,0,0);
        16:     return (op == 8'hE7) ? mk(1,0,0,0,0,0,0,0,0,0,0,0,0,0,0) : '0;
        17:     return (op == 8'hE7) ? mk(1,0,0,0,0,0,0,0,0,0,0,0,0,0,1) : '0;
        18:     return expTaken(op,z,c,s) ? mk(0,0,0,0,0,0,0,0,0,0,0,0,0,1,0) : '0;
        19:     return expTaken(op,z,c,s) ? mk(0,0,0,0,0,1,0,0,0,0,0,0,0,1,0) : '0;
        default: return '0;
      endcase
    end
    return '0;
  endfunction

  function automatic string reqOf(input int st, input logic [7:0] op);
    if (st <= 2) return "R2";
    if (st <= 5) return "R3";
    case (opKind(op))
      1, 2: return "R5";
      3: return "R4";
      4: return "R6";
      5: return (st >= 16) ? ((op == 8'hE7) ? "R9" : "R8") : "R7";
      6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // runs one instruction; assumes stateNum==1 at a negedge
  task automatic runOp(input logic [7:0] op, input bit z, c, s);
    int cnt = 0;
    int st;
    zFlag = z; cyFlag = c; sFlag = s;
    do begin
      st = int'(stateNum);
      check(actVec() == expVec(st, op, z, c, s), reqOf(st, op),
            $sformatf("strobes op=%02h state=%0d", op, st), actVec(), expVec(st, op, z, c, s));
      if (opKind(op) == 3)
        check(aluFunc == ((st == 6 || st == 7) ? op[2:0] : 3'b000), "R4",
              $sformatf("aluFunc op=%02h state=%0d", op, st), aluFunc, 0);
      if (st == 2) instrReg = op;
      @(negedge clk);
      cnt++;
    end while (stateNum != 5'd1 && cnt < 40);
    check(cnt == expLen(op), "R12", $sformatf("length op=%02h", op), cnt, expLen(op));
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] op;
    void'($urandom(32'h5EC0_1234));
    repeat (3) @(negedge clk);
    check(stateNum == 5'd1 && !halted, "R1", "state in reset", stateNum, 1);
    check(actVec() == expVec(1, 8'h00, 0, 0, 0), "R1", "strobes in reset", actVec(), expVec(1, 8'h00, 0, 0, 0));
    rstN = 1'b1;
    // directed classes
    runOp(8'h81, 0, 0, 0);  // ALU inc
    runOp(8'h8E, 0, 0, 0);  // ALU shl to D
    runOp(8'h1A, 0, 0, 0);  // mov8
    runOp(8'h75, 0, 0, 0);  // ldi
    runOp(8'hA4, 0, 0, 0);  // mov16
    runOp(8'hB0, 0, 0, 0);  // undefined
    runOp(8'hFF, 0, 0, 0);  // undefined
    runOp(8'hE6, 0, 0, 0);  // goto, flags low
    runOp(8'hE7, 0, 0, 0);  // call, flags low
    runOp(8'hF0, 0, 0, 1); runOp(8'hF0, 1, 1, 0);
    runOp(8'hE8, 0, 1, 0); runOp(8'hE8, 1, 0, 1);
    runOp(8'hE4, 1, 0, 0); runOp(8'hE4, 0, 1, 1);
    runOp(8'hE2, 0, 0, 0); runOp(8'hE2, 1, 1, 1);
    // random opcodes and flags
    for (int i = 0; i < 300; i++) begin
      op = 8'($urandom);
      if (op == 8'hAE) op = 8'hA0;
      if (i % 4 == 0) op = 8'hE0 | {4'b0, 4'($urandom)};
      runOp(op, 1'($urandom), 1'($urandom), 1'($urandom));
    end
    // R10: halt
    for (int st = 1; st <= 6; st++) begin
      check(int'(stateNum) == st && actVec() == ((st <= 5) ? expVec(st, 8'hAE, 0, 0, 0) : '0),
            "R10", $sformatf("halt lead-in state=%0d", st), actVec(), st);
      if (st == 2) instrReg = 8'hAE;
      @(negedge clk);
    end
    for (int i = 0; i < 5; i++) begin
      check(halted && stateNum == 5'd6 && actVec() == '0, "R10", "frozen after halt",
            {halted, stateNum, actVec()}, {1'b1, 5'd6, 15'd0});
      @(negedge clk);
    end
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    check(stateNum == 5'd1 && !halted, "R1", "state after reset from halt", {halted, stateNum}, 1);
    runOp(8'h84, 0, 0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule